// File: doc/BRIEF.md
# Programmable Acknowledge Merge Tree

This block combines the acknowledge levels returned by the logic cells that receive copies of a single incoming channel into one merged acknowledge. It is a balanced binary tree of two-input Muller C-elements (one fewer than the number of cells served). Each element input has its own small configuration field, so the tree can be wired to form a single large copy group or split into several disjoint groups. Every element's output is brought out as a tap, so each group's merged acknowledge is read from the tap of the element at the group's apex. A cluster with K-input logic cells uses K copies of this block, one per input port index. A channel is only ever copied across cells on the same port index, and slack buffer inputs never take part.

Elements sit in heap order. Element 0 is the root, and the children of element i are elements 2i+1 and 2i+2 where those exist. Each element is modelled as a clocked state-holding cell. Its output rises one clock after both of its effective inputs are high, falls one clock after both are low, and otherwise holds. A group therefore settles within as many clocks as the tree has levels. A configuration word is captured on a load strobe, and every element's state is cleared on that same edge.

Top module: `ack_copy_tree`

## Requirements
- R1: While reset is asserted and after its release with no configuration loaded, every tap is low, whatever the acknowledge inputs do. The reset configuration marks every element input as unused.
- R2: The configuration word holds one field of SEL_W = clog2(NC+2) bits per element input. The field for input s (0 or 1) of element i sits at bits [(2i+s)*SEL_W +: SEL_W]. Code j < NC selects acknowledge input j.
- R3: Code NC on an element input that has a child (element 2i+1+s exists) selects that child's tap, so children can be chained into one group. For NC=5, a 5-way group is built as elements 3, 1, 2 feeding element 0.
- R4: If exactly one input of an element is used, the element follows that input alone.
- R5: An element whose two inputs are both unused (code above NC, or code NC where no child exists) keeps its tap low.
- R6: A group's apex tap goes high only after every acknowledge in the group is high. Each element output rises one clock after both of its effective inputs are high.
- R7: A group's apex tap goes low only after every acknowledge in the group is low. Each element output falls one clock after both of its effective inputs are low.
- R8: While an element's effective inputs disagree, its tap holds its value.
- R9: Acknowledge inputs not selected anywhere in a group have no effect on that group's tap.
- R10: Asserting cfgWe captures cfgWord and clears every element to low on the same clock edge. Normal merging resumes on the following edges.
- R11: Code NC on an input that has no child counts as unused, so an element with that code and an unused partner stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load strobe for cfgWord; also clears all element states |
| cfgWord | input | 2*(NC-1)*SEL_W | Per-input select fields, layout as in R2 |
| ackIn | input | NC | Acknowledge level from port k of each logic cell |
| tapOut | output | NC-1 | Output of every C-element, index = heap position |

## Verification
The following properties are checked on every clock and for every element by the bound checker:
- an element rises only after both effective inputs were high;
- it falls only after both were low, or after a clear;
- it holds while its inputs disagree;
- an inactive element stays low;
- a load leaves all taps low.

Whether a group's apex tap waits for the whole group depends on how the configuration fields chain elements together. The bench covers this, along with field positions, code meanings, single-input pass-through and the independence of unselected acknowledges. It sweeps five groupings of a five-cell tree through rotated raise and fall orders and compares each tap with an arithmetic group model.

// File: rtl/ack_tree_pkg.sv
package ack_tree_pkg;

  // Strobes from the control half to the element datapath.
  typedef struct packed {
    logic clearState;  // force every element low this edge
    logic evalEnable;  // let elements follow their inputs this edge
  } treeStrobe_t;

endpackage

// File: rtl/ack_tree_ctrl.sv
module ack_tree_ctrl
  import ack_tree_pkg::*;
#(
  parameter int CFG_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  output logic [CFG_W-1:0] cfgQ,
  output treeStrobe_t      strobe
);

  // All-ones marks every element input unused after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '1;
    end else if (cfgWe) begin
      cfgQ <= cfgWord;
    end
  end

  always_comb begin
    strobe.clearState = cfgWe;
    strobe.evalEnable = ~cfgWe;
  end

endmodule

// File: rtl/ack_tree_celem.sv
module ack_tree_celem (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic en,
  input  logic active,
  input  logic inA,
  input  logic inB,
  output logic q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= 1'b0;
    end else if (clear) begin
      q <= 1'b0;
    end else if (en) begin
      if (!active) begin
        q <= 1'b0;
      end else if (inA && inB) begin
        q <= 1'b1;
      end else if (!inA && !inB) begin
        q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ack_tree_datapath.sv
module ack_tree_datapath
  import ack_tree_pkg::*;
#(
  parameter int NC    = 5,
  parameter int NODES = NC - 1,
  parameter int SEL_W = 3,
  parameter int CFG_W = 2 * NODES * SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NC-1:0]    ackIn,
  input  logic [CFG_W-1:0] cfgQ,
  input  treeStrobe_t      strobe,
  output logic [NODES-1:0] tapQ,
  output logic [NODES-1:0] effA,
  output logic [NODES-1:0] effB,
  output logic [NODES-1:0] nodeActive
);

  localparam int PORTS = 2 * NODES;
  localparam logic [SEL_W-1:0] CHILD_CODE = SEL_W'(NC);

  logic [PORTS-1:0] portVal;
  logic [PORTS-1:0] portUsed;

  function automatic logic pickAck(input logic [SEL_W-1:0] code,
                                   input logic [NC-1:0] acks);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < NC; j++) begin
      if (code == SEL_W'(j)) hit = acks[j];
    end
    return hit;
  endfunction

  // One selector per element input; the child option exists only where the
  // heap position of the child falls inside the tree.
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int OWNER = p / 2;
    localparam int SIDE  = p % 2;
    localparam int CHILD = 2 * OWNER + 1 + SIDE;
    logic [SEL_W-1:0] code;
    assign code = cfgQ[p*SEL_W +: SEL_W];
    if (CHILD < NODES) begin : g_child
      assign portVal[p]  = (code == CHILD_CODE) ? tapQ[CHILD] : pickAck(code, ackIn);
      assign portUsed[p] = (code <= CHILD_CODE);
    end else begin : g_leaf
      assign portVal[p]  = pickAck(code, ackIn);
      assign portUsed[p] = (code < CHILD_CODE);
    end
  end

  // Elements: an unused side mirrors the used one.
  for (genvar n = 0; n < NODES; n++) begin : g_node
    assign nodeActive[n] = portUsed[2*n] | portUsed[2*n+1];
    assign effA[n] = portUsed[2*n]   ? portVal[2*n]   : portVal[2*n+1];
    assign effB[n] = portUsed[2*n+1] ? portVal[2*n+1] : portVal[2*n];

    ack_tree_celem u_celem (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.clearState),
      .en     (strobe.evalEnable),
      .active (nodeActive[n]),
      .inA    (effA[n]),
      .inB    (effB[n]),
      .q      (tapQ[n])
    );
  end

endmodule

// File: rtl/ack_copy_tree.sv
module ack_copy_tree
  import ack_tree_pkg::*;
#(
  parameter  int NC    = 5,
  localparam int NODES = NC - 1,
  localparam int SEL_W = $clog2(NC + 2),
  localparam int CFG_W = 2 * NODES * SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [NC-1:0]    ackIn,
  output logic [NODES-1:0] tapOut
);

  logic [CFG_W-1:0] cfgQ;
  treeStrobe_t      strobe;
  logic [NODES-1:0] effA;
  logic [NODES-1:0] effB;
  logic [NODES-1:0] nodeActive;

  ack_tree_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgWord (cfgWord),
    .cfgQ    (cfgQ),
    .strobe  (strobe)
  );

  ack_tree_datapath #(
    .NC(NC), .NODES(NODES), .SEL_W(SEL_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ackIn      (ackIn),
    .cfgQ       (cfgQ),
    .strobe     (strobe),
    .tapQ       (tapOut),
    .effA       (effA),
    .effB       (effB),
    .nodeActive (nodeActive)
  );

endmodule

// File: rtl/ack_copy_tree_checker.sv
module ack_copy_tree_checker #(
  parameter int NODES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [NODES-1:0] tapQ,
  input logic [NODES-1:0] effA,
  input logic [NODES-1:0] effB,
  input logic [NODES-1:0] nodeActive
);

  for (genvar n = 0; n < NODES; n++) begin : g_chk
    p_rise_both_high_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(tapQ[n]) |-> $past(effA[n] && effB[n] && nodeActive[n]));

    p_fall_both_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(tapQ[n]) |-> $past(cfgWe || !nodeActive[n] || (!effA[n] && !effB[n])));

    p_hold_on_disagree_r8: assert property (@(posedge clk) disable iff (!rstN)
      (($past(effA[n]) != $past(effB[n])) && $past(nodeActive[n]) && !$past(cfgWe))
        |-> $stable(tapQ[n]));

    p_idle_stays_low_r5: assert property (@(posedge clk) disable iff (!rstN)
      !nodeActive[n] |=> !tapQ[n]);
  end

  p_load_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (tapQ == '0));

endmodule

bind ack_copy_tree ack_copy_tree_checker #(.NODES(NODES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWe      (cfgWe),
  .tapQ       (tapOut),
  .effA       (effA),
  .effB       (effB),
  .nodeActive (nodeActive)
);

// File: tb/tb_ack_copy_tree.sv
module tb_ack_copy_tree;

  localparam int CLK_PERIOD = 10;
  localparam int NC     = 5;
  localparam int NODES  = NC - 1;
  localparam int SEL_W  = 3;
  localparam int CFG_W  = 2 * NODES * SEL_W;
  localparam int SETTLE = 5;
  localparam logic [SEL_W-1:0] UNUSED = 3'd7;
  localparam logic [SEL_W-1:0] CHILD  = 3'd5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [CFG_W-1:0] cfgWord = '0;
  logic [NC-1:0]    ackIn = '0;
  logic [NODES-1:0] tapOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // Group model: up to two groups plus a set of taps that must stay low.
  logic [NC-1:0]    gMask [2];
  int               gTap [2];
  int               gCount;
  logic [NODES-1:0] zeroTaps;
  logic             expState [2];

  ack_copy_tree #(.NC(NC)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgWord (cfgWord),
    .ackIn   (ackIn),
    .tapOut  (tapOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Field for input s of element i at bits (2i+s)*SEL_W (R2).
  function automatic logic [CFG_W-1:0] mkCfg(
      input logic [SEL_W-1:0] n0a, input logic [SEL_W-1:0] n0b,
      input logic [SEL_W-1:0] n1a, input logic [SEL_W-1:0] n1b,
      input logic [SEL_W-1:0] n2a, input logic [SEL_W-1:0] n2b,
      input logic [SEL_W-1:0] n3a, input logic [SEL_W-1:0] n3b);
    return {n3b, n3a, n2b, n2a, n1b, n1a, n0b, n0a};
  endfunction

  task automatic check(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b ack=%b taps=%b", tag, actual, expected, ackIn, tapOut);
    end
  endtask

  task automatic loadCfg(input logic [CFG_W-1:0] w);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWord = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    for (int g = 0; g < gCount; g++) begin
      string stepTag;
      if ((ackIn & gMask[g]) == gMask[g]) begin
        expState[g] = 1'b1;
        stepTag = "R6";
      end else if ((ackIn & gMask[g]) == '0) begin
        expState[g] = 1'b0;
        stepTag = "R7";
      end else begin
        stepTag = "R8";
      end
      check({tag, " ", stepTag, " R9"}, tapOut[gTap[g]], expState[g]);
    end
    for (int t = 0; t < NODES; t++) begin
      if (zeroTaps[t]) check({tag, " R5 idle"}, tapOut[t], 1'b0);
    end
  endtask

  task automatic runScenario(input string tag, input logic [CFG_W-1:0] w);
    ackIn = '0;
    loadCfg(w);
    expState[0] = 1'b0;
    expState[1] = 1'b0;
    for (int r = 0; r < NC; r++) begin
      for (int j = 0; j < NC; j++) begin
        ackIn[(r + j) % NC] = 1'b1;
        repeat (SETTLE) @(negedge clk);
        checkAll(tag);
      end
      for (int j = 0; j < NC; j++) begin
        ackIn[(r + 2*j) % NC] = 1'b0;
        repeat (SETTLE) @(negedge clk);
        checkAll(tag);
      end
    end
  endtask

  initial begin
    // R1: reset state with acknowledges high.
    ackIn = '1;
    repeat (3) @(negedge clk);
    for (int t = 0; t < NODES; t++) check("R1 in reset", tapOut[t], 1'b0);
    rstN = 1'b1;
    repeat (SETTLE) @(negedge clk);
    for (int t = 0; t < NODES; t++) check("R1 after release", tapOut[t], 1'b0);
    ackIn = '0;

    // R3: full 5-way chain.
    gCount = 1; gMask[0] = 5'b11111; gTap[0] = 0; zeroTaps = '0;
    runScenario("R3 five-way", mkCfg(CHILD, CHILD, CHILD, 3'd2, 3'd3, 3'd4, 3'd0, 3'd1));

    // R10: reload clears on the load edge, then merging resumes.
    ackIn = '1;
    repeat (SETTLE) @(negedge clk);
    check("R10 before reload", tapOut[0], 1'b1);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    for (int t = 0; t < NODES; t++) check("R10 cleared", tapOut[t], 1'b0);
    repeat (SETTLE) @(negedge clk);
    check("R10 resumed", tapOut[0], 1'b1);
    ackIn = '0;

    // R2 and R5: 3-way plus 2-way, root idle.
    gCount = 2;
    gMask[0] = 5'b00111; gTap[0] = 1;
    gMask[1] = 5'b11000; gTap[1] = 2;
    zeroTaps = 4'b0001;
    runScenario("R2 three+two", mkCfg(UNUSED, UNUSED, CHILD, 3'd2, 3'd3, 3'd4, 3'd0, 3'd1));

    // R2: two 2-way groups on scattered inputs, two idle elements.
    gCount = 2;
    gMask[0] = 5'b01010; gTap[0] = 3;
    gMask[1] = 5'b10001; gTap[1] = 2;
    zeroTaps = 4'b0011;
    runScenario("R2 two+two", mkCfg(UNUSED, UNUSED, UNUSED, UNUSED, 3'd0, 3'd4, 3'd1, 3'd3));

    // R4: 4-way with a single-input element in the chain; input 0 ignored.
    gCount = 1; gMask[0] = 5'b11110; gTap[0] = 0; zeroTaps = '0;
    runScenario("R4 four-way", mkCfg(CHILD, CHILD, CHILD, UNUSED, 3'd3, 3'd4, 3'd1, 3'd2));

    // R11: 3-way; element 3 has child code where no child exists.
    gCount = 1; gMask[0] = 5'b10101; gTap[0] = 0; zeroTaps = 4'b1000;
    runScenario("R11 three-way", mkCfg(CHILD, CHILD, 3'd2, UNUSED, 3'd0, 3'd4, CHILD, UNUSED));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule